// File: doc/BRIEF.md
# Parallel Port Register and Interrupt Logic

This block is the host-side register file and interrupt source of a PC-style bidirectional parallel port. A narrow register bus reaches five registers: the data latch, the pin status, the line control, a read-only configuration word, and the extended control register. The extended control register holds the operating mode. The block drives the eight data lines and four control lines with an output-enable. It samples five status lines and the acknowledge pin, and takes two flags and a service request from an external FIFO engine. A single level-sensitive `irq` output goes to the interrupt controller.

The acknowledge interrupt behaves differently in each mode. In the extended bidirectional mode (mode code 001) a low-to-high return of the acknowledge pin is captured. The capture shows in status bit 2 and holds `irq` high until software reads the status register. In every other mode, `irq` simply tracks the synchronized pin while the interrupt is enabled, and status bit 2 stays at 1. A FIFO service path runs beside it. Software clears the service bit to arm it, and the hardware sets the bit again when it raises the interrupt, which tells a shared-line handler that this port was the source. In configuration mode a read-only word reports the wired IRQ line as a 3-bit code and mirrors the interrupt output.

Top module: `pp_port_intc`

## Requirements
- R1: After reset the mode field is 000 (SPP), `pd_oe` is 1 and `irq` is 0. The control register reads 0xC0. The extended control register reads 0x04 with the FIFO flag bits added, so 0x05 when only empty is set. With `st_in`=0 the status register reads 0x07.
- R2: The register select codes are data=0, status=1, control=2, config word=5 and extended control=6; any other code reads 0xFF. In the extended control register, bits 7:5 (mode), 4:3 (spare) and 2 (service) are writable and read back. Bit 1 reads `fifo_full` and bit 0 reads `fifo_empty`, and neither can be written. Writing 0x34 while the FIFO is empty and not full reads back 0x35.
- R3: Control bits 3:0 drive `ctl_out`. Control bit 5 set to 1 in any mode other than SPP drops `pd_oe`, and a data read then returns `pd_in`. In SPP mode bit 5 has no effect: `pd_oe` stays 1 and a data read returns the written latch. `pd_out` always equals the latch.
- R4: In mode 001 with control bit 4 set, a low-to-high transition of `ack_n_in` sets a capture flag within 4 clocks. The flag reads as status bit 2 = 0 and drives `irq` high. While the pin is low, `irq` stays low.
- R5: In mode 001, a status read clears the capture, so status bit 2 returns to 1 and `irq` falls on the next clock. If a new capture falls in the same clock as the read, the capture wins and stays set.
- R6: In every mode other than 001, with control bit 4 set, `irq` is 1 while the synchronized `ack_n_in` is low and 0 while it is high, and status bit 2 reads 1. Any capture is discarded on leaving mode 001.
- R7: With control bit 4 clear, the acknowledge pin neither raises `irq` nor sets the capture in any mode.
- R8: While extended control bit 2 is 0 and `fifo_req` is 1, the hardware sets bit 2 and raises `irq`. `irq` then stays high after `fifo_req` drops, until software writes the extended control register. With bit 2 at 1, `fifo_req` has no effect. A register write that clears bit 2 takes priority over a hardware set in the same clock.
- R9: In mode 111 the config word reads {0, `irq`, code, 000}. The code maps the IRQ_LINE parameter as 7→1, 9→2, 10→3, 11→4, 14→5, 15→6, 5→7, and any other line→0. In any other mode the config word reads 0xFF.
- R10: Status bits 7:3 read `st_in[4:0]` and bits 1:0 read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, carries the status-read side effect |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| pd_in | input | 8 | Data line levels seen at the pins |
| pd_out | output | 8 | Data output latch |
| pd_oe | output | 1 | Data line output enable |
| ctl_out | output | 4 | Control line outputs |
| st_in | input | 5 | Status line levels |
| ack_n_in | input | 1 | Asynchronous acknowledge pin, active low |
| fifo_empty | input | 1 | FIFO empty flag from the transfer engine |
| fifo_full | input | 1 | FIFO full flag from the transfer engine |
| fifo_req | input | 1 | FIFO service request from the transfer engine |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of events can fall in one clock. The first pair is a status read and a fresh acknowledge capture. The bench raises the pin and holds a status read exactly across the clock in which the synchronized edge lands. It then expects status bit 2 at 0 and `irq` still high. The second pair is a software write that clears the service bit while `fifo_req` is already high. The bench expects the bit to read 0 for one clock and then be set again by the hardware. Random rounds mix the mode, the enable, the pulse width and the status lines against a bench model.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;
  localparam int CTL_W = 4;
  localparam int ST_W  = 5;

  localparam logic [SEL_W-1:0] SEL_DATA = 3'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CFGW = 3'd5;
  localparam logic [SEL_W-1:0] SEL_XCTL = 3'd6;

  localparam logic [2:0] MODE_SPP = 3'b000;
  localparam logic [2:0] MODE_BID = 3'b001;
  localparam logic [2:0] MODE_CFG = 3'b111;

  function automatic logic [2:0] irq_line_code(input int unsigned line);
    case (line)
      7:       return 3'd1;
      9:       return 3'd2;
      10:      return 3'd3;
      11:      return 3'd4;
      14:      return 3'd5;
      15:      return 3'd6;
      5:       return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic [ST_W-1:0] lines,
                                                   input logic ack_bit);
    return {lines, ack_bit, 2'b11};
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input logic dir, input logic en,
                                                 input logic [CTL_W-1:0] lines);
    return {2'b11, dir, en, lines};
  endfunction

  function automatic logic [REG_W-1:0] pack_xctl(input logic [2:0] mode,
                                                 input logic [1:0] spare,
                                                 input logic svc,
                                                 input logic full,
                                                 input logic empty);
    return {mode, spare, svc, full, empty};
  endfunction

  function automatic logic [REG_W-1:0] pack_cfgw(input logic irq_now,
                                                 input logic [2:0] code);
    return {1'b0, irq_now, code, 3'b000};
  endfunction
endpackage

// File: rtl/pp_ack_sync.sv
module pp_ack_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_in,
  output logic ack_lvl,
  output logic ack_rise
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '1;
      prev_q <= 1'b1;
    end else begin
      chain[0] <= ack_n_in;
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[LAST];
    end
  end

  assign ack_lvl  = chain[LAST];
  assign ack_rise = chain[LAST] & ~prev_q;
endmodule

// File: rtl/pp_ack_capture.sv
module pp_ack_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic bid_mode,
  input  logic ack_en,
  input  logic ack_rise,
  input  logic stat_rd,
  output logic ack_latch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ack_latch <= 1'b0;
    else if (!bid_mode)           ack_latch <= 1'b0;
    else if (ack_en && ack_rise)  ack_latch <= 1'b1;
    else if (stat_rd)             ack_latch <= 1'b0;
  end
endmodule

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             fifo_req,
  output logic [REG_W-1:0] data_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             dir_q,
  output logic             ack_en,
  output logic [2:0]       mode_q,
  output logic [1:0]       spare_q,
  output logic             svc_q,
  output logic             fifo_pend,
  output logic             xctl_wr
);
  logic data_wr, ctrl_wr, svc_hw_set;

  assign data_wr    = bus_wr && (bus_sel == SEL_DATA);
  assign ctrl_wr    = bus_wr && (bus_sel == SEL_CTRL);
  assign xctl_wr    = bus_wr && (bus_sel == SEL_XCTL);
  assign svc_hw_set = !svc_q && fifo_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (data_wr) data_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      dir_q  <= 1'b0;
      ack_en <= 1'b0;
    end else if (ctrl_wr) begin
      ctl_q  <= bus_wdata[CTL_W-1:0];
      ack_en <= bus_wdata[4];
      dir_q  <= bus_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_SPP;
      spare_q   <= 2'b00;
      svc_q     <= 1'b1;
      fifo_pend <= 1'b0;
    end else if (xctl_wr) begin
      mode_q    <= bus_wdata[7:5];
      spare_q   <= bus_wdata[4:3];
      svc_q     <= bus_wdata[2];
      fifo_pend <= 1'b0;
    end else if (svc_hw_set) begin
      svc_q     <= 1'b1;
      fifo_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/pp_readmux.sv
module pp_readmux
  import pp_pkg::*;
#(
  parameter int IRQ_LINE = 7
) (
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [REG_W-1:0] data_q,
  input  logic [REG_W-1:0] pd_in,
  input  logic             pd_oe,
  input  logic [ST_W-1:0]  st_in,
  input  logic             stat_bit2,
  input  logic             dir_q,
  input  logic             ack_en,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic [2:0]       mode_q,
  input  logic [1:0]       spare_q,
  input  logic             svc_q,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             irq,
  output logic [REG_W-1:0] rdata
);
  localparam logic [2:0] LINE_CODE = irq_line_code(IRQ_LINE);

  always_comb begin
    case (bus_sel)
      SEL_DATA: rdata = pd_oe ? data_q : pd_in;
      SEL_STAT: rdata = pack_status(st_in, stat_bit2);
      SEL_CTRL: rdata = pack_ctrl(dir_q, ack_en, ctl_q);
      SEL_CFGW: rdata = (mode_q == MODE_CFG) ? pack_cfgw(irq, LINE_CODE) : '1;
      SEL_XCTL: rdata = pack_xctl(mode_q, spare_q, svc_q, fifo_full, fifo_empty);
      default:  rdata = '1;
    endcase
  end
endmodule

// File: rtl/pp_port_intc.sv
module pp_port_intc
  import pp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_LINE    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [REG_W-1:0] pd_in,
  output logic [REG_W-1:0] pd_out,
  output logic             pd_oe,
  output logic [CTL_W-1:0] ctl_out,
  input  logic [ST_W-1:0]  st_in,
  input  logic             ack_n_in,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic             fifo_req,
  output logic             irq
);
  logic [REG_W-1:0] data_q;
  logic [CTL_W-1:0] ctl_q;
  logic             dir_q, ack_en, svc_q, fifo_pend, xctl_wr;
  logic [2:0]       mode_q;
  logic [1:0]       spare_q;
  logic             ack_lvl, ack_rise, ack_latch;
  logic             bid_mode, stat_rd, ack_cond, stat_bit2;

  assign bid_mode = (mode_q == MODE_BID);
  assign stat_rd  = bus_rd && (bus_sel == SEL_STAT);

  pp_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .fifo_req  (fifo_req),
    .data_q    (data_q),
    .ctl_q     (ctl_q),
    .dir_q     (dir_q),
    .ack_en    (ack_en),
    .mode_q    (mode_q),
    .spare_q   (spare_q),
    .svc_q     (svc_q),
    .fifo_pend (fifo_pend),
    .xctl_wr   (xctl_wr)
  );

  pp_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n_in (ack_n_in),
    .ack_lvl  (ack_lvl),
    .ack_rise (ack_rise)
  );

  pp_ack_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .bid_mode  (bid_mode),
    .ack_en    (ack_en),
    .ack_rise  (ack_rise),
    .stat_rd   (stat_rd),
    .ack_latch (ack_latch)
  );

  assign ack_cond  = bid_mode ? ack_latch : ~ack_lvl;
  assign irq       = (ack_en & ack_cond) | fifo_pend;
  assign stat_bit2 = bid_mode ? ~ack_latch : 1'b1;
  assign pd_oe     = !(dir_q && (mode_q != MODE_SPP));
  assign pd_out    = data_q;
  assign ctl_out   = ctl_q;

  pp_readmux #(.IRQ_LINE(IRQ_LINE)) u_rd (
    .bus_sel    (bus_sel),
    .data_q     (data_q),
    .pd_in      (pd_in),
    .pd_oe      (pd_oe),
    .st_in      (st_in),
    .stat_bit2  (stat_bit2),
    .dir_q      (dir_q),
    .ack_en     (ack_en),
    .ctl_q      (ctl_q),
    .mode_q     (mode_q),
    .spare_q    (spare_q),
    .svc_q      (svc_q),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .irq        (irq),
    .rdata      (bus_rdata)
  );
endmodule

// File: rtl/pp_port_intc_chk.sv
module pp_port_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_q,
  input logic       pd_oe,
  input logic       ack_en,
  input logic       ack_rise,
  input logic       ack_latch,
  input logic       stat_rd,
  input logic       svc_q,
  input logic       fifo_req,
  input logic       xctl_wr,
  input logic       fifo_pend,
  input logic       irq
);
  p_spp_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000) |-> pd_oe);

  p_edge_captured_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b001 && ack_en && ack_rise) |=> (ack_latch && irq));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b001 && ack_latch && stat_rd && !ack_rise) |=> !ack_latch);

  p_hold_until_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b001 && ack_latch && !stat_rd && !xctl_wr) |=> ack_latch);

  p_no_capture_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 3'b001) |=> !ack_latch);

  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_en && !fifo_pend) |-> !irq);

  p_service_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_q && fifo_req && !xctl_wr) |=> (svc_q && irq));
endmodule

bind pp_port_intc pp_port_intc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_q    (mode_q),
  .pd_oe     (pd_oe),
  .ack_en    (ack_en),
  .ack_rise  (ack_rise),
  .ack_latch (ack_latch),
  .stat_rd   (stat_rd),
  .svc_q     (svc_q),
  .fifo_req  (fifo_req),
  .xctl_wr   (xctl_wr),
  .fifo_pend (fifo_pend),
  .irq       (irq)
);

// File: tb/pp_port_intc_test.sv
`timescale 1ns/100ps
module pp_port_intc_test;
  localparam logic [2:0] S_DATA = 3'd0, S_STAT = 3'd1, S_CTRL = 3'd2,
                         S_CFGW = 3'd5, S_XCTL = 3'd6;
  localparam int LINE = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_sel = 3'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pd_in = 8'h00;
  logic [7:0] pd_out;
  logic       pd_oe;
  logic [3:0] ctl_out;
  logic [4:0] st_in = 5'd0;
  logic       ack_n_in = 1'b1;
  logic       fifo_empty = 1'b1, fifo_full = 1'b0, fifo_req = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pp_port_intc #(.SYNC_STAGES(2), .IRQ_LINE(LINE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_in(pd_in), .pd_out(pd_out),
    .pd_oe(pd_oe), .ctl_out(ctl_out), .st_in(st_in), .ack_n_in(ack_n_in),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_req(fifo_req), .irq(irq)
  );

  function automatic logic [2:0] exp_code(input int line);
    int tbl [7] = '{7, 9, 10, 11, 14, 15, 5};
    for (int i = 0; i < 7; i++) if (tbl[i] == line) return 3'(i + 1);
    return 3'd0;
  endfunction

  function automatic logic [7:0] exp_status(input logic [4:0] s, input logic captured);
    logic [7:0] v;
    v = 8'h07;
    v[7:3] = s;
    if (captured) v[2] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    step(1);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    step(1);
    bus_sel = s; bus_rd = 1'b1;
    #0.2 d = bus_rdata;
    step(1);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [7:0] d);
    bus_sel = s;
    #0.2 d = bus_rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20061106));
    step(2);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 pd_oe", {7'd0, pd_oe}, 8'h01);
    peek(S_CTRL, v); chk("R1 control", v, 8'hC0);
    peek(S_XCTL, v); chk("R1 extended control", v, 8'h05);
    peek(S_STAT, v); chk("R1 status", v, 8'h07);

    // R2 extended control read-only flags
    wr(S_XCTL, 8'h34);
    peek(S_XCTL, v); chk("R2 0x34 readback", v, 8'h35);
    fifo_empty = 1'b0; fifo_full = 1'b1;
    peek(S_XCTL, v); chk("R2 flags follow", v, 8'h36);
    peek(3'd3, v); chk("R2 unused select", v, 8'hFF);
    fifo_empty = 1'b1; fifo_full = 1'b0;
    wr(S_XCTL, 8'h04);

    // R3 direction and control lines
    pd_in = 8'h3C;
    wr(S_DATA, 8'hA5);
    wr(S_CTRL, 8'h2B);
    chk("R3 ctl_out", {4'd0, ctl_out}, 8'h0B);
    chk("R3 spp ignores dir", {7'd0, pd_oe}, 8'h01);
    peek(S_DATA, v); chk("R3 spp data reads latch", v, 8'hA5);
    wr(S_XCTL, 8'h24);
    chk("R3 bid input dir", {7'd0, pd_oe}, 8'h00);
    peek(S_DATA, v); chk("R3 data reads pins", v, 8'h3C);
    chk("R3 pd_out latch", pd_out, 8'hA5);
    wr(S_CTRL, 8'h00);
    chk("R3 output again", {7'd0, pd_oe}, 8'h01);

    // R7 enable clear in bidirectional mode
    ack_n_in = 1'b0; step(4);
    chk("R7 low no irq", {7'd0, irq}, 8'h00);
    ack_n_in = 1'b1; step(4);
    chk("R7 edge no irq", {7'd0, irq}, 8'h00);
    peek(S_STAT, v); chk("R7 no capture", v, exp_status(st_in, 1'b0));

    // R5 status read in the same clock as the capture
    wr(S_CTRL, 8'h10);
    ack_n_in = 1'b0; step(4);
    ack_n_in = 1'b1;
    step(2);
    bus_sel = S_STAT; bus_rd = 1'b1;
    #0.2 v = bus_rdata;
    chk("R5 before capture", v, exp_status(st_in, 1'b0));
    step(1);
    bus_rd = 1'b0;
    chk("R5 capture beats read irq", {7'd0, irq}, 8'h01);
    peek(S_STAT, v); chk("R5 capture beats read bit", v, exp_status(st_in, 1'b1));
    rd(S_STAT, v);
    chk("R5 read clears irq", {7'd0, irq}, 8'h00);

    // R6 capture dropped when leaving mode 001
    ack_n_in = 1'b0; step(4); ack_n_in = 1'b1; step(4);
    chk("R4 captured", {7'd0, irq}, 8'h01);
    wr(S_XCTL, 8'h04);
    wr(S_XCTL, 8'h24);
    chk("R6 capture discarded", {7'd0, irq}, 8'h00);
    wr(S_XCTL, 8'h04);

    // R8 FIFO service path
    wr(S_CTRL, 8'h00);
    wr(S_XCTL, 8'h00);
    peek(S_XCTL, v); chk("R8 armed", v, 8'h01);
    chk("R8 idle irq", {7'd0, irq}, 8'h00);
    fifo_req = 1'b1; step(2);
    chk("R8 service irq", {7'd0, irq}, 8'h01);
    peek(S_XCTL, v); chk("R8 bit set", v, 8'h05);
    fifo_req = 1'b0; step(3);
    chk("R8 holds", {7'd0, irq}, 8'h01);
    wr(S_XCTL, 8'h04);
    chk("R8 write clears", {7'd0, irq}, 8'h00);
    fifo_req = 1'b1; step(3);
    chk("R8 masked", {7'd0, irq}, 8'h00);
    wr(S_XCTL, 8'h00);
    peek(S_XCTL, v); chk("R8 write wins", v, 8'h01);
    step(1);
    peek(S_XCTL, v); chk("R8 set next clock", v, 8'h05);
    chk("R8 set irq", {7'd0, irq}, 8'h01);
    fifo_req = 1'b0;
    wr(S_XCTL, 8'h04);

    // R9 configuration word
    wr(S_XCTL, 8'hE4);
    peek(S_CFGW, v); chk("R9 code", v, {2'b00, exp_code(LINE), 3'b000});
    wr(S_CTRL, 8'h10);
    ack_n_in = 1'b0; step(3);
    peek(S_CFGW, v); chk("R9 irq bit", v, {2'b01, exp_code(LINE), 3'b000});
    chk("R6 cfg mode follows pin", {7'd0, irq}, 8'h01);
    ack_n_in = 1'b1; step(3);
    wr(S_XCTL, 8'h04);
    peek(S_CFGW, v); chk("R9 hidden", v, 8'hFF);
    wr(S_CTRL, 8'h00);

    // random rounds: R4 R5 R6 R7 R10
    for (int it = 0; it < 40; it++) begin
      logic bid, en, cap;
      int hold;
      bid = 1'($urandom % 2);
      en  = 1'($urandom % 2);
      hold = 3 + int'($urandom % 4);
      st_in = 5'($urandom);
      wr(S_XCTL, {bid ? 3'b001 : 3'b000, 5'b00100});
      wr(S_CTRL, {3'b000, en, 4'h0});
      rd(S_STAT, v);
      step(2);
      ack_n_in = 1'b0;
      step(hold);
      chk(bid ? "R4 no irq while low" : "R6 irq follows low",
          {7'd0, irq}, {7'd0, !bid && en});
      ack_n_in = 1'b1;
      step(4);
      cap = bid && en;
      chk(bid ? "R4 irq after edge" : "R6 irq after high", {7'd0, irq}, {7'd0, cap});
      peek(S_STAT, v);
      chk("R10 status lines and bit 2", v, exp_status(st_in, cap));
      rd(S_STAT, v);
      chk("R5 cleared by read", {7'd0, irq}, 8'h00);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule